// File: doc/BRIEF.md
# Circular-Shift Noise Sample Distributor

This block hands one W-bit perturbation sample to every variable node of a parallel bit-flip decoder. It does not place a random generator in each node. Instead it keeps one slot per node in a circular shift register. Once per decoder iteration, on an advance strobe, every slot passes its value to the next slot. Each node therefore reads a different sample in every iteration, even though the hardware holds only one sample per node.

There are two ways to fill the ring.

- **Ring mode:** samples written in advance through the load port travel around the ring and come back to where they started. No generator is needed.
- **Shared mode:** slot 0 takes its value from one shared generator input. The chain carries that stream out to every node position.

A copy of the preloaded pattern is kept on the side. A synchronous clear copies it back into the ring, so every frame starts with the samples lined up the same way.

Top module: `noise_ring_dist`

## Requirements
- R1: After reset, every slot of `samples` reads zero.
- R2: When `load_en` is high and `clear` is low, the slot at `load_addr` takes `load_data` one cycle later. All other slots keep their values. Slot i sits at bits `[i*W +: W]` of `samples`.
- R3: With `mode_sel`=0 (ring mode), an `advance` pulse without load or clear moves slot i's value into slot i+1, and the last slot's value into slot 0, one cycle later.
- R4: With `mode_sel`=1 (shared mode), an `advance` pulse without load or clear moves slot i's value into slot i+1, and `gen_sample` into slot 0, one cycle later.
- R5: An `advance` pulse given while `load_en` is high does not shift the ring; only the load takes effect.
- R6: `clear` copies every pattern value written through the load port back into the ring one cycle later. Clear takes priority: a load or advance given with it is dropped, and it also leaves the stored pattern unchanged.
- R7: In ring mode, N advances in a row bring the ring back to the loaded pattern.
- R8: Without `advance`, `load_en` or `clear`, the ring holds its values whatever happens on `gen_sample` or `mode_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one pattern sample |
| load_addr | input | $clog2(N_SLOTS) | Slot written by the load |
| load_data | input | SAMPLE_W | Sample value to write |
| advance | input | 1 | Per-iteration shift strobe |
| clear | input | 1 | Restore the stored pattern into the ring |
| mode_sel | input | 1 | 0 ring recirculation, 1 shared generator feed |
| gen_sample | input | SAMPLE_W | Shared generator sample |
| samples | output | N_SLOTS*SAMPLE_W | All slot values, slot i at [i*W +: W] |

## Verification
The ring is preloaded with a pattern of distinct values, so any misplaced slot shows up as a wrong value. A single ring advance shows whether the direction of the shift and the wrap from the last slot are right. A full lap of N advances shows whether the ring comes back to the starting pattern. A shared-mode run feeds in three distinct generator values; their order along the chain proves that slot 0 takes the generator input and the shift carries it onward. Loads combined with advance, and clears combined with both load and advance, check the priorities. Changing `gen_sample` and `mode_sel` while no advance is given checks that the ring holds.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
   typedef enum logic {
      MODE_RING   = 1'b0,
      MODE_SHARED = 1'b1
   } nsd_mode_e;
endpackage

// File: rtl/nsd_shadow_store.sv
module nsd_shadow_store #(
   parameter int N_SLOTS  = 8,
   parameter int SAMPLE_W = 4,
   localparam int AW = $clog2(N_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_i,
   input  logic [AW-1:0]               addr_i,
   input  logic [SAMPLE_W-1:0]         data_i,
   output logic [N_SLOTS*SAMPLE_W-1:0] pattern_o
);
   // Keeps the preloaded pattern for the clear restore.
   for (genvar i = 0; i < N_SLOTS; i++) begin : g_keep
      always_ff @(posedge clk) begin
         if (rst)
            pattern_o[i*SAMPLE_W +: SAMPLE_W] <= '0;
         else if (wr_i && (addr_i == AW'(i)))
            pattern_o[i*SAMPLE_W +: SAMPLE_W] <= data_i;
      end
   end
endmodule

// File: rtl/nsd_entry_select.sv
module nsd_entry_select
   import nsd_pkg::*;
#(
   parameter int SAMPLE_W  = 4,
   parameter bit SHARED_EN = 1'b1
) (
   input  logic [SAMPLE_W-1:0] wrap_i,
   input  logic [SAMPLE_W-1:0] gen_i,
   input  logic                mode_i,
   output logic [SAMPLE_W-1:0] feed_o
);
   if (SHARED_EN) begin : g_shared
      always_comb feed_o = (nsd_mode_e'(mode_i) == MODE_SHARED) ? gen_i : wrap_i;
   end else begin : g_ring_only
      logic unused_in;
      always_comb unused_in = mode_i ^ (^gen_i);
      always_comb feed_o = wrap_i;
   end
endmodule

// File: rtl/nsd_ring_core.sv
module nsd_ring_core #(
   parameter int N_SLOTS  = 8,
   parameter int SAMPLE_W = 4,
   localparam int AW = $clog2(N_SLOTS),
   localparam int RW = N_SLOTS * SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clr_i,
   input  logic                load_i,
   input  logic [AW-1:0]       addr_i,
   input  logic [SAMPLE_W-1:0] data_i,
   input  logic                adv_i,
   input  logic [SAMPLE_W-1:0] feed_i,
   input  logic [RW-1:0]       shadow_i,
   output logic [RW-1:0]       ring_q
);
   logic [RW-1:0] prev_w;

   always_comb prev_w = {ring_q[RW-SAMPLE_W-1:0], feed_i};

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)
            ring_q[i*SAMPLE_W +: SAMPLE_W] <= '0;
         else if (clr_i)
            ring_q[i*SAMPLE_W +: SAMPLE_W] <= shadow_i[i*SAMPLE_W +: SAMPLE_W];
         else if (load_i) begin
            if (addr_i == AW'(i))
               ring_q[i*SAMPLE_W +: SAMPLE_W] <= data_i;
         end else if (adv_i)
            ring_q[i*SAMPLE_W +: SAMPLE_W] <= prev_w[i*SAMPLE_W +: SAMPLE_W];
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!adv_i && !load_i && !clr_i) |=> $stable(ring_q));
   assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !load_i && !clr_i) |=>
         ring_q[2*SAMPLE_W-1:SAMPLE_W] == $past(ring_q[SAMPLE_W-1:0]));
   assert_entry_R4: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !load_i && !clr_i) |=> ring_q[SAMPLE_W-1:0] == $past(feed_i));
   assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> ring_q == $past(shadow_i));
   assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (load_i && !clr_i && addr_i == '0) |=> ring_q[SAMPLE_W-1:0] == $past(data_i));
endmodule

// File: rtl/noise_ring_dist.sv
module noise_ring_dist #(
   parameter int N_SLOTS   = 8,
   parameter int SAMPLE_W  = 4,
   parameter bit SHARED_EN = 1'b1,
   localparam int AW = $clog2(N_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        load_en,
   input  logic [AW-1:0]               load_addr,
   input  logic [SAMPLE_W-1:0]         load_data,
   input  logic                        advance,
   input  logic                        clear,
   input  logic                        mode_sel,
   input  logic [SAMPLE_W-1:0]         gen_sample,
   output logic [N_SLOTS*SAMPLE_W-1:0] samples
);
   initial begin
      assert (N_SLOTS >= 2) else $error("N_SLOTS must be at least 2");
      assert (SAMPLE_W >= 1) else $error("SAMPLE_W must be at least 1");
   end

   logic [N_SLOTS*SAMPLE_W-1:0] pattern_w;
   logic [SAMPLE_W-1:0]         feed_w;
   logic                        shadow_wr;

   always_comb shadow_wr = load_en && !clear;

   nsd_shadow_store #(.N_SLOTS(N_SLOTS), .SAMPLE_W(SAMPLE_W)) u_shadow (
      .clk(clk), .rst(rst), .wr_i(shadow_wr), .addr_i(load_addr),
      .data_i(load_data), .pattern_o(pattern_w));

   nsd_entry_select #(.SAMPLE_W(SAMPLE_W), .SHARED_EN(SHARED_EN)) u_entry (
      .wrap_i(samples[N_SLOTS*SAMPLE_W-1 -: SAMPLE_W]), .gen_i(gen_sample),
      .mode_i(mode_sel), .feed_o(feed_w));

   nsd_ring_core #(.N_SLOTS(N_SLOTS), .SAMPLE_W(SAMPLE_W)) u_core (
      .clk(clk), .rst(rst), .clr_i(clear), .load_i(load_en), .addr_i(load_addr),
      .data_i(load_data), .adv_i(advance), .feed_i(feed_w),
      .shadow_i(pattern_w), .ring_q(samples));
endmodule

// File: tb/noise_ring_dist_tb.sv
module noise_ring_dist_tb;
   localparam int N = 8;
   localparam int W = 4;
   localparam int AW = $clog2(N);

   logic clk = 0, rst = 1, load_en = 0, advance = 0, clear = 0, mode_sel = 0;
   logic [AW-1:0] load_addr = '0;
   logic [W-1:0] load_data = '0, gen_sample = '0;
   logic [N*W-1:0] samples;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [W-1:0] exp_r [N];
   logic [W-1:0] exp_s [N];

   always #4 clk = ~clk;

   noise_ring_dist #(.N_SLOTS(N), .SAMPLE_W(W)) u_dut (
      .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
      .load_data(load_data), .advance(advance), .clear(clear),
      .mode_sel(mode_sel), .gen_sample(gen_sample), .samples(samples));

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      load_en = 0; advance = 0; clear = 0;
   endtask

   task automatic check_all(string req);
      for (int i = 0; i < N; i++) begin
         checks++;
         if (samples[i*W +: W] !== exp_r[i]) begin
            errors++;
            $display("FAIL %s slot %0d actual=%0h expected=%0h", req, i,
                     samples[i*W +: W], exp_r[i]);
         end
      end
   endtask

   task automatic model_adv(logic [W-1:0] feed);
      for (int i = N-1; i > 0; i--) exp_r[i] = exp_r[i-1];
      exp_r[0] = feed;
   endtask

   task automatic t_reset();
      for (int i = 0; i < N; i++) begin exp_r[i] = '0; exp_s[i] = '0; end
      rst = 1; tick(); tick(); rst = 0;
      check_all("R1");
   endtask

   task automatic t_load();
      for (int i = 0; i < N; i++) begin
         load_en = 1; load_addr = AW'(i); load_data = W'((i*5+3) & 15);
         tick();
         exp_r[i] = W'((i*5+3) & 15); exp_s[i] = exp_r[i];
         idle();
         check_all("R2");
      end
   endtask

   task automatic t_ring_adv();
      mode_sel = 0;
      advance = 1; tick(); idle();
      model_adv(exp_r[N-1]);
      check_all("R3");
      for (int k = 1; k < N; k++) begin
         advance = 1; tick();
         model_adv(exp_r[N-1]);
      end
      idle();
      for (int i = 0; i < N; i++) exp_r[i] = exp_s[i];
      check_all("R7");
   endtask

   task automatic t_hold();
      for (int k = 0; k < 4; k++) begin
         gen_sample = W'(k + 9); mode_sel = k[0];
         tick();
      end
      mode_sel = 0;
      check_all("R8");
   endtask

   task automatic t_shared();
      mode_sel = 1;
      for (int k = 0; k < 3; k++) begin
         gen_sample = W'(9 + k); advance = 1; tick();
         model_adv(W'(9 + k));
      end
      idle(); mode_sel = 0;
      check_all("R4");
   endtask

   task automatic t_load_blocks_adv();
      load_en = 1; advance = 1; load_addr = AW'(5); load_data = 4'hE;
      tick(); idle();
      exp_r[5] = 4'hE; exp_s[5] = 4'hE;
      check_all("R5");
   endtask

   task automatic t_clear();
      clear = 1; load_en = 1; advance = 1; load_addr = AW'(2); load_data = 4'hF;
      tick(); idle();
      for (int i = 0; i < N; i++) exp_r[i] = exp_s[i];
      check_all("R6");
      advance = 1; tick(); idle();
      model_adv(exp_r[N-1]);
      clear = 1; tick(); idle();
      for (int i = 0; i < N; i++) exp_r[i] = exp_s[i];
      check_all("R6");
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #2;
      t_reset();
      t_load();
      t_ring_adv();
      t_hold();
      t_shared();
      t_load_blocks_adv();
      t_clear();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule